// File: doc/BRIEF.md
# Multicast Group Hash Filter

This block decides whether a received frame sent to a group address is wanted. The receive side presents the six destination-address bytes one at a time, in the order they arrive on the wire. The first byte comes with a start strobe. The block runs a reflected CRC-32 over those bytes, starting from all ones and consuming each byte least significant bit first. It bit-reverses the 32-bit remainder without a final inversion and takes the top eight bits of the reversed value as an index into a 256-entry hash table.

The table is eight 32-bit words. The upper three index bits choose the word. The lower five bits count from the word's most significant bit, so index bit number n lands on word bit 31 − n. Entry 0 is therefore the top bit of word 0, and entry 255 is the bottom bit of word 7. A host port can overwrite a whole word, or set or clear one entry and leave the rest of its word unchanged. A readback select exposes any word.

One cycle after the last address byte, the block pulses a result-valid flag. With it come the computed index and a hit flag. The hit flag is raised only when the address is a group address (bit 0 of the first byte is 1) and the selected table entry is 1.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset all eight table words read back as zero, `match_valid` is 0, and no address can produce a hit until an entry is set.
- R2: A host access with `cfg_op` = 0 (word write) replaces word `cfg_reg` with `cfg_wdata` at the next clock edge.
- R3: A host access with `cfg_op` = 1 (entry set) sets only the table bit chosen by `cfg_entry`; every other bit of the table keeps its value.
- R4: A host access with `cfg_op` = 2 (entry clear) clears only the table bit chosen by `cfg_entry`; every other bit keeps its value.
- R5: A host access with `cfg_op` = 3 changes nothing in the table.
- R6: `match_idx` equals bits 31..24 of the bit-reversed CRC-32 of the six address bytes. The CRC is reflected (polynomial 0xEDB88320, each byte fed LSB first), seeded with 0xFFFFFFFF and not inverted afterwards.
- R7: Entry e lives in word e[7:5] at bit position 31 − e[4:0]. Entry 0 is bit 31 of word 0; entry 255 is bit 0 of word 7.
- R8: `match_valid` is high for exactly the one cycle that follows the clock edge at which the sixth address byte is accepted, and is low otherwise.
- R9: `match_hit` is 1 only together with `match_valid`, and only when bit 0 of the first address byte is 1 and the indexed entry is 1. The entry is taken as it stood before any host access in the same cycle.
- R10: A start strobe arriving while an address is still being collected discards the partial address and begins a new one with that byte.
- R11: Bytes with `rx_valid` high and no start strobe, when no address is open, are ignored and produce no result.
- R12: Idle cycles (`rx_valid` low) between address bytes do not change the computed index or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Host access strobe |
| cfg_op | input | 2 | Host operation: 0 word write, 1 entry set, 2 entry clear, 3 no effect |
| cfg_reg | input | 3 | Word selected by a word write |
| cfg_entry | input | 8 | Entry number for set and clear |
| cfg_wdata | input | 32 | Word write data |
| rd_sel | input | 3 | Readback word select |
| rd_data | output | 32 | Selected table word, combinational |
| rx_start | input | 1 | Marks the first byte of a destination address |
| rx_valid | input | 1 | Address byte valid |
| rx_byte | input | 8 | Address byte, wire order |
| match_valid | output | 1 | Result pulse, one cycle after the last byte |
| match_hit | output | 1 | Frame accepted by the group hash |
| match_idx | output | 8 | Hash index of the last completed address |

## Verification
Every cycle, the assertions check the host-side table updates: word writes landing, single-entry set and clear, and the no-effect code leaving the table stable. They also check the reset state and the framing of the result, meaning that a hit only ever comes with a valid pulse, pulses never arrive back to back, and every pulse follows an accepted byte. The hash itself cannot be expressed as a simple property. Correct indices, the bit mapping at entries 0 and 255, abort on a restarted address, ignored stray bytes and tolerance of gaps are all shown by the bench's scenarios. In those scenarios a behavioural model predicts the outputs on every clock.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam int unsigned DEF_NUM_REGS   = 8;
    localparam int unsigned DEF_REG_W      = 32;
    localparam int unsigned DEF_ADDR_BYTES = 6;

    localparam int unsigned CRC_W          = 32;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_SEED      = 32'hFFFFFFFF;

    typedef enum logic [1:0] {
        CFG_WORD = 2'd0,
        CFG_SET  = 2'd1,
        CFG_CLR  = 2'd2,
        CFG_NOP  = 2'd3
    } cfg_op_e;

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic             group;
        logic             active;
    } crc_state_t;

    // One byte through a reflected CRC-32, least significant bit first.
    function automatic logic [CRC_W-1:0] crc32_refl_byte(
        input logic [CRC_W-1:0] cur,
        input logic [7:0]       din
    );
        logic [CRC_W-1:0] r;
        r = cur ^ {{(CRC_W-8){1'b0}}, din};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/mhf_crc_engine.sv
module mhf_crc_engine
    import mhf_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = DEF_ADDR_BYTES,
    parameter int unsigned IDX_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_start,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    output logic             fin_valid,
    output logic             fin_group,
    output logic [IDX_W-1:0] fin_idx
);
    localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);

    crc_state_t       st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             take;
    logic [CRC_W-1:0] seed;

    assign take = rx_valid && (rx_start || st_q.active);

    always_comb begin
        seed         = rx_start ? CRC_SEED : st_q.crc;
        st_n.crc     = crc32_refl_byte(seed, rx_byte);
        st_n.group   = rx_start ? rx_byte[0] : st_q.group;
        cnt_n        = rx_start ? CNT_W'(1) : cnt_q + CNT_W'(1);
        fin_valid    = take && (cnt_n == CNT_W'(ADDR_BYTES));
        st_n.active  = !fin_valid;
        fin_group    = st_n.group;
        // Top bits of the bit-reversed remainder are its low bits, mirrored.
        for (int j = 0; j < int'(IDX_W); j++) begin
            fin_idx[IDX_W-1-j] = st_n.crc[j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            cnt_q <= '0;
        end else if (take) begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table
    import mhf_pkg::*;
#(
    parameter int unsigned NUM_REGS = DEF_NUM_REGS,
    parameter int unsigned REG_W    = DEF_REG_W
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   cfg_we,
    input  logic [1:0]                             cfg_op,
    input  logic [$clog2(NUM_REGS)-1:0]            cfg_reg,
    input  logic [$clog2(NUM_REGS*REG_W)-1:0]      cfg_entry,
    input  logic [REG_W-1:0]                       cfg_wdata,
    output logic [NUM_REGS*REG_W-1:0]              tbl_flat
);
    localparam int unsigned SEL_W = $clog2(NUM_REGS);
    localparam int unsigned POS_W = $clog2(REG_W);
    localparam int unsigned IDX_W = SEL_W + POS_W;

    logic [SEL_W-1:0] ent_sel;
    logic [POS_W-1:0] ent_bit;
    cfg_op_e          op;

    assign ent_sel = cfg_entry[IDX_W-1:POS_W];
    // Positions count from the word's MSB: bit n is word bit REG_W-1-n.
    assign ent_bit = ~cfg_entry[POS_W-1:0];
    assign op      = cfg_op_e'(cfg_op);

    for (genvar r = 0; r < int'(NUM_REGS); r++) begin : g_word
        logic [REG_W-1:0] word_q, word_n;
        logic             ent_here, word_here;

        assign ent_here  = (ent_sel == SEL_W'(r));
        assign word_here = (cfg_reg == SEL_W'(r));

        always_comb begin
            word_n = word_q;
            if (cfg_we) begin
                case (op)
                    CFG_WORD: if (word_here) word_n = cfg_wdata;
                    CFG_SET:  if (ent_here)  word_n[ent_bit] = 1'b1;
                    CFG_CLR:  if (ent_here)  word_n[ent_bit] = 1'b0;
                    default:  word_n = word_q;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (rst) word_q <= '0;
            else     word_q <= word_n;
        end

        assign tbl_flat[r*REG_W +: REG_W] = word_q;
    end

endmodule

// File: rtl/mhf_lookup.sv
module mhf_lookup
    import mhf_pkg::*;
#(
    parameter int unsigned NUM_REGS = DEF_NUM_REGS,
    parameter int unsigned REG_W    = DEF_REG_W
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              fin_valid,
    input  logic                              fin_group,
    input  logic [$clog2(NUM_REGS*REG_W)-1:0] fin_idx,
    input  logic [NUM_REGS*REG_W-1:0]         tbl_flat,
    output logic                              match_valid,
    output logic                              match_hit,
    output logic [$clog2(NUM_REGS*REG_W)-1:0] match_idx
);
    localparam int unsigned POS_W = $clog2(REG_W);
    localparam int unsigned IDX_W = $clog2(NUM_REGS*REG_W);

    logic [IDX_W-1:0] loc;
    logic             entry;

    // Word index stays, in-word position is mirrored (MSB numbering).
    assign loc   = {fin_idx[IDX_W-1:POS_W], ~fin_idx[POS_W-1:0]};
    assign entry = tbl_flat[loc];

    always_ff @(posedge clk) begin
        if (rst) begin
            match_valid <= 1'b0;
            match_hit   <= 1'b0;
            match_idx   <= '0;
        end else begin
            match_valid <= fin_valid;
            match_hit   <= fin_valid && fin_group && entry;
            if (fin_valid) match_idx <= fin_idx;
        end
    end

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
    import mhf_pkg::*;
#(
    parameter int unsigned NUM_REGS   = DEF_NUM_REGS,
    parameter int unsigned REG_W      = DEF_REG_W,
    parameter int unsigned ADDR_BYTES = DEF_ADDR_BYTES
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cfg_we,
    input  logic [1:0]                        cfg_op,
    input  logic [$clog2(NUM_REGS)-1:0]       cfg_reg,
    input  logic [$clog2(NUM_REGS*REG_W)-1:0] cfg_entry,
    input  logic [REG_W-1:0]                  cfg_wdata,
    input  logic [$clog2(NUM_REGS)-1:0]       rd_sel,
    output logic [REG_W-1:0]                  rd_data,
    input  logic                              rx_start,
    input  logic                              rx_valid,
    input  logic [7:0]                        rx_byte,
    output logic                              match_valid,
    output logic                              match_hit,
    output logic [$clog2(NUM_REGS*REG_W)-1:0] match_idx
);
    localparam int unsigned IDX_W  = $clog2(NUM_REGS*REG_W);
    localparam int unsigned FLAT_W = NUM_REGS * REG_W;

    logic [FLAT_W-1:0] tbl_flat;
    logic              fin_valid;
    logic              fin_group;
    logic [IDX_W-1:0]  fin_idx;

    mhf_crc_engine #(
        .ADDR_BYTES (ADDR_BYTES),
        .IDX_W      (IDX_W)
    ) u_crc (
        .clk       (clk),
        .rst       (rst),
        .rx_start  (rx_start),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .fin_valid (fin_valid),
        .fin_group (fin_group),
        .fin_idx   (fin_idx)
    );

    mhf_hash_table #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W)
    ) u_tbl (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_op    (cfg_op),
        .cfg_reg   (cfg_reg),
        .cfg_entry (cfg_entry),
        .cfg_wdata (cfg_wdata),
        .tbl_flat  (tbl_flat)
    );

    mhf_lookup #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W)
    ) u_look (
        .clk         (clk),
        .rst         (rst),
        .fin_valid   (fin_valid),
        .fin_group   (fin_group),
        .fin_idx     (fin_idx),
        .tbl_flat    (tbl_flat),
        .match_valid (match_valid),
        .match_hit   (match_hit),
        .match_idx   (match_idx)
    );

    assign rd_data = tbl_flat[rd_sel*REG_W +: REG_W];

endmodule

// File: rtl/mhf_checker.sv
module mhf_checker
    import mhf_pkg::*;
#(
    parameter int unsigned NUM_REGS   = DEF_NUM_REGS,
    parameter int unsigned REG_W      = DEF_REG_W,
    parameter int unsigned ADDR_BYTES = DEF_ADDR_BYTES
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              cfg_we,
    input logic [1:0]                        cfg_op,
    input logic [$clog2(NUM_REGS)-1:0]       cfg_reg,
    input logic [$clog2(NUM_REGS*REG_W)-1:0] cfg_entry,
    input logic [REG_W-1:0]                  cfg_wdata,
    input logic                              rx_valid,
    input logic                              match_valid,
    input logic                              match_hit,
    input logic [NUM_REGS*REG_W-1:0]         tbl_flat
);
    localparam int unsigned SEL_W = $clog2(NUM_REGS);
    localparam int unsigned POS_W = $clog2(REG_W);
    localparam int unsigned IDX_W = SEL_W + POS_W;

    logic [IDX_W-1:0] ent_loc_q;
    logic [SEL_W-1:0] word_sel_q;
    logic [REG_W-1:0] word_now;

    always_ff @(posedge clk) begin
        ent_loc_q  <= {cfg_entry[IDX_W-1:POS_W], ~cfg_entry[POS_W-1:0]};
        word_sel_q <= cfg_reg;
    end

    assign word_now = tbl_flat[word_sel_q*REG_W +: REG_W];

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tbl_flat == '0) && !match_valid);                      // R1
    AST_WORD_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_op == CFG_WORD) |=> word_now == $past(cfg_wdata));      // R2
    AST_ENTRY_SET: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_op == CFG_SET) |=> tbl_flat[ent_loc_q]);                // R3
    AST_ENTRY_SET_ONLY: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_op == CFG_SET) |=>
            $countones(tbl_flat ^ $past(tbl_flat)) <= 1);                      // R3
    AST_ENTRY_CLR: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_op == CFG_CLR) |=> !tbl_flat[ent_loc_q]);               // R4
    AST_ENTRY_CLR_ONLY: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_op == CFG_CLR) |=>
            $countones(tbl_flat ^ $past(tbl_flat)) <= 1);                      // R4
    AST_NOP_STABLE: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_op == CFG_NOP) |=> $stable(tbl_flat));                  // R5
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(tbl_flat));                                         // R5
    AST_VALID_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        match_valid |-> $past(rx_valid));                                       // R8
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (ADDR_BYTES > 1) && match_valid |=> !match_valid);                      // R8
    AST_HIT_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        match_hit |-> match_valid);                                             // R9

endmodule

bind mcast_hash_filter mhf_checker #(
    .NUM_REGS   (NUM_REGS),
    .REG_W      (REG_W),
    .ADDR_BYTES (ADDR_BYTES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_op      (cfg_op),
    .cfg_reg     (cfg_reg),
    .cfg_entry   (cfg_entry),
    .cfg_wdata   (cfg_wdata),
    .rx_valid    (rx_valid),
    .match_valid (match_valid),
    .match_hit   (match_hit),
    .tbl_flat    (tbl_flat)
);

// File: tb/mcast_hash_filter_test.sv
module mcast_hash_filter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_op = 2'd0;
    logic [2:0]  cfg_reg = 3'd0;
    logic [7:0]  cfg_entry = 8'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [2:0]  rd_sel = 3'd0;
    logic [31:0] rd_data;
    logic        rx_start = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'd0;
    logic        match_valid;
    logic        match_hit;
    logic [7:0]  match_idx;

    always #10 clk = ~clk;

    mcast_hash_filter uut (
        .clk (clk), .rst (rst),
        .cfg_we (cfg_we), .cfg_op (cfg_op), .cfg_reg (cfg_reg),
        .cfg_entry (cfg_entry), .cfg_wdata (cfg_wdata),
        .rd_sel (rd_sel), .rd_data (rd_data),
        .rx_start (rx_start), .rx_valid (rx_valid), .rx_byte (rx_byte),
        .match_valid (match_valid), .match_hit (match_hit), .match_idx (match_idx)
    );

    // Behavioural model state
    int unsigned m_tbl [8];
    int unsigned m_crc;
    int          m_cnt;
    bit          m_open, m_grp;
    bit          e_valid, e_hit;
    int unsigned e_idx;

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit    finished = 0;

    function automatic int unsigned m_crc_byte(int unsigned c, int unsigned b);
        for (int i = 0; i < 8; i++) begin
            bit fb = ((c ^ (b >> i)) & 1) != 0;
            c = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
        end
        return c;
    endfunction

    // Top 8 bits of the bit-reversed remainder.
    function automatic int unsigned m_index(int unsigned c);
        int unsigned idx = 0;
        for (int j = 0; j < 8; j++) idx = (idx << 1) | ((c >> j) & 1);
        return idx;
    endfunction

    function automatic int unsigned addr_index(logic [47:0] a);
        int unsigned c = 32'hFFFFFFFF;
        for (int k = 0; k < 6; k++) c = m_crc_byte(c, a[47-8*k -: 8]);
        return m_index(c);
    endfunction

    function automatic bit m_entry(int unsigned e);
        return ((m_tbl[e / 32] >> (31 - (e % 32))) & 1) != 0;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic model_pre();
        e_valid = 0;
        e_hit   = 0;
        if (rst) begin
            foreach (m_tbl[i]) m_tbl[i] = 0;
            m_open = 0;
            m_cnt  = 0;
            return;
        end
        if (rx_valid && (rx_start || m_open)) begin
            if (rx_start) begin
                m_crc = m_crc_byte(32'hFFFFFFFF, rx_byte);
                m_grp = rx_byte[0];
                m_cnt = 1;
            end else begin
                m_crc = m_crc_byte(m_crc, rx_byte);
                m_cnt++;
            end
            m_open = 1;
            if (m_cnt == 6) begin
                e_valid = 1;
                e_idx   = m_index(m_crc);
                e_hit   = m_grp && m_entry(e_idx);
                m_open  = 0;
            end
        end
        if (cfg_we) begin
            case (cfg_op)
                2'd0: m_tbl[cfg_reg] = cfg_wdata;
                2'd1: m_tbl[cfg_entry / 32] |=  (32'h1 << (31 - cfg_entry % 32));
                2'd2: m_tbl[cfg_entry / 32] &= ~(32'h1 << (31 - cfg_entry % 32));
                default: ;
            endcase
        end
    endtask

    task automatic tick();
        model_pre();
        @(posedge clk);
        @(negedge clk);
        chk(match_valid === e_valid, cur_req, "match_valid (R8)", match_valid, e_valid);
        if (e_valid) begin
            chk(match_idx === e_idx[7:0], "R6", "match_idx", match_idx, e_idx);
            chk(match_hit === e_hit, cur_req, "match_hit (R9)", match_hit, e_hit);
        end else begin
            chk(match_hit === 1'b0, "R9", "match_hit without valid", match_hit, 0);
        end
        chk(rd_data === m_tbl[rd_sel], cur_req, "rd_data", rd_data, m_tbl[rd_sel]);
    endtask

    task automatic host(logic [1:0] op, logic [2:0] r, logic [7:0] e, logic [31:0] d);
        cfg_we = 1; cfg_op = op; cfg_reg = r; cfg_entry = e; cfg_wdata = d;
        tick();
        cfg_we = 0;
    endtask

    task automatic read_all();
        for (int r = 0; r < 8; r++) begin
            rd_sel = 3'(r);
            tick();
        end
    endtask

    task automatic send(logic [47:0] a, int gap);
        for (int k = 0; k < 6; k++) begin
            rx_valid = 1; rx_start = (k == 0); rx_byte = a[47-8*k -: 8];
            tick();
            rx_valid = 0; rx_start = 0;
            if (k < 5) repeat (gap) tick();
        end
    endtask

    task automatic fill(logic [31:0] d);
        for (int r = 0; r < 8; r++) host(2'd0, 3'(r), 8'd0, d);
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R8 watchdog expired: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [47:0] ga, ua, ba;
        int unsigned gi;
        int          seen;

        rst = 1;
        repeat (3) tick();
        rst = 0;

        // R1: empty table after reset, no hit
        cur_req = "R1";
        read_all();
        ga = 48'h01005E0000FB;
        send(ga, 0);
        chk(match_hit === 1'b0, "R1", "hit on empty table", match_hit, 0);

        // R2: word writes
        cur_req = "R2";
        for (int r = 0; r < 8; r++) host(2'd0, 3'(r), 8'd0, 32'hA5000000 | (r * 32'h01010101));
        read_all();
        fill(32'h0);

        // R3, R7, R9: set the address's entry, then hit
        cur_req = "R3";
        gi = addr_index(ga);
        host(2'd1, 3'd0, gi[7:0], 0);
        rd_sel = gi[7:5]; tick();
        chk(rd_data === (32'h1 << (31 - gi[4:0])), "R7", "entry position", rd_data,
            32'h1 << (31 - gi[4:0]));
        cur_req = "R9";
        send(ga, 0);
        chk(match_hit === 1'b1, "R9", "group hit", match_hit, 1);

        // R9: same entry, individual address never hits
        ua = {ga[47:41], 1'b0, ga[39:0]};
        host(2'd1, 3'd0, addr_index(ua), 0);
        send(ua, 1);
        chk(match_hit === 1'b0, "R9", "individual address", match_hit, 0);

        // R4: clear removes the hit
        cur_req = "R4";
        host(2'd0, 3'd5, 0, 32'hFFFFFFFF);
        host(2'd2, 3'd0, gi[7:0], 0);
        read_all();
        send(ga, 0);
        chk(match_hit === 1'b0, "R4", "hit after clear", match_hit, 0);

        // R5: no-effect code
        cur_req = "R5";
        host(2'd3, 3'd5, 8'hA0, 32'h0);
        rd_sel = 3'd5; tick();
        chk(rd_data === 32'hFFFFFFFF, "R5", "word after nop", rd_data, 32'hFFFFFFFF);

        // R7: corner entries
        cur_req = "R7";
        fill(32'h0);
        host(2'd1, 3'd0, 8'd0, 0);
        rd_sel = 3'd0; tick();
        chk(rd_data === 32'h80000000, "R7", "entry 0", rd_data, 32'h80000000);
        host(2'd1, 3'd0, 8'd255, 0);
        rd_sel = 3'd7; tick();
        chk(rd_data === 32'h00000001, "R7", "entry 255", rd_data, 1);

        // R10: restart mid-address
        cur_req = "R10";
        fill(32'hFFFFFFFF);
        ba = 48'h3333FF001122;
        for (int k = 0; k < 3; k++) begin
            rx_valid = 1; rx_start = (k == 0); rx_byte = ba[47-8*k -: 8];
            tick();
        end
        rx_valid = 0; rx_start = 0;
        send(ga, 0);
        chk(match_idx === addr_index(ga), "R10", "index after restart", match_idx, addr_index(ga));

        // R11: stray bytes ignored
        cur_req = "R11";
        seen = 0;
        for (int k = 0; k < 8; k++) begin
            rx_valid = 1; rx_byte = 8'(k * 37 + 1);
            tick();
            seen += match_valid;
        end
        rx_valid = 0;
        tick();
        chk(seen == 0, "R11", "results from stray bytes", seen, 0);

        // R12: gaps between bytes
        cur_req = "R12";
        send(ga, 3);
        chk(match_idx === addr_index(ga), "R12", "index with gaps", match_idx, addr_index(ga));

        // R6: random addresses and tables
        cur_req = "R6";
        void'($urandom(32'h5EED));
        for (int n = 0; n < 40; n++) begin
            if (n % 8 == 0) fill($urandom);
            send({$urandom, 16'($urandom)}, n % 3);
        end

        tick();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule